// File: doc/BRIEF.md
# CAN Bus and Pin Wake-Up Detector

This block watches for wake-up requests while a CAN transceiver sits in one of its low-power modes (standby, go-to-sleep or sleep). Two sources are handled. A remote request comes from the low-power bus receiver as a dominant/recessive indication. It is accepted only after a full pattern of two dominant phases, each long enough and each followed by a long enough recessive phase. A local request comes from the digitised level of the wake pin. It is accepted when that level changes in either direction and then holds steady for a debounce time.

Durations are counted in pulses of a low-rate clock enable, so the thresholds are plain tick counts given as parameters. The block keeps two flags: a general wake-up flag, set by either source, and a local wake-up flag, set only by the pin. It also drives the direction of the wake pin's bias current. The current pulls up while the accepted pin level is high and pulls down while it is low. The mode controller feeds in the operating mode, a blocking input for the undervoltage waiting time, the power-up flag, and one-cycle pulses for power-up and undervoltage-flag events.

Top module: `canwk_detector`

## Requirements
- R1: After reset, `wake_flag` and `local_flag` are 0 and `wake_pull_up` is 0, meaning pull-down.
- R2: Mode encoding: 0 normal, 1 receive-only, 2 standby, 3 go-to-sleep, 4 sleep. In modes 2, 3 and 4, `bus_dom` must show two dominant phases of at least DOM_TICKS ticks each, and each must be followed by a recessive phase of at least REC_TICKS ticks. `wake_flag` is then set one clock after the final recessive phase reaches REC_TICKS ticks.
- R3: If any dominant or recessive phase of the remote pattern ends before its minimum, the pattern is discarded. The next dominant phase starts a fresh pattern.
- R4: In modes 2 to 4, a change of `wake_lvl` that stays stable for WAKE_TICKS ticks sets both `wake_flag` and `local_flag`. A change that reverts sooner sets nothing.
- R5: `wake_pull_up` takes the new `wake_lvl` value in the same clock in which a change is accepted (1 = pull-up, 0 = pull-down). This happens in every mode, and `wake_pull_up` never changes otherwise.
- R6: In mode 0 or mode 1, neither flag is set by any bus or pin activity, and the remote pattern is held in its idle state.
- R7: While `uv_block` is 1, neither flag is set and the remote pattern is held idle.
- R8: While `pwrup_flag` is 1, a local wake-up sets `wake_flag` but not `local_flag`.
- R9: `local_flag` clears one clock after a `pwrup_evt` pulse, and one clock after the mode leaves 0. Entering mode 0 leaves it unchanged.
- R10: `wake_flag` clears one clock after a `pwrup_evt` or `uv_set` pulse, and one clock after the mode enters 0. A clear wins over a simultaneous set.
- R11: Durations advance only in clocks where `tick` is 1. With `tick` held at 0, no pattern and no pin change is ever accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Low-rate clock enable used for all duration counts |
| mode | input | 3 | Operating mode (0 normal, 1 receive-only, 2 standby, 3 go-to-sleep, 4 sleep) |
| bus_dom | input | 1 | Low-power receiver output, 1 = bus dominant |
| wake_lvl | input | 1 | Digitised wake pin level |
| uv_block | input | 1 | Undervoltage waiting time in progress, blocks wake-up detection |
| pwrup_flag | input | 1 | Power-up flag currently set |
| pwrup_evt | input | 1 | One-cycle power-up event |
| uv_set | input | 1 | One-cycle pulse: supply undervoltage flag being set |
| wake_flag | output | 1 | Wake-up flag (bus or pin) |
| local_flag | output | 1 | Local (pin) wake-up flag |
| wake_pull_up | output | 1 | Wake pin bias direction, 1 = pull-up, 0 = pull-down |

## Verification
The assertions check these properties on every cycle:
- No flag rises in normal or receive-only mode, while detection is blocked, or (for the local flag) while the power-up flag is set.
- Each clear event empties its flag in the following cycle.
- The bias direction only ever moves to the previously sampled pin level.

The bench scenarios cover what depends on whole histories. The bench sweeps the lengths of the first three remote phases against the dominant and recessive thresholds. It sweeps the length of a pin pulse against the debounce time, from both resting levels. It checks the exact clock in which the remote flag and the tick-gated pin acceptance appear.

// File: rtl/canwk_pkg.sv
// Package: shared types for the wake-up detector.
// Assumes the mode controller supplies the 3-bit mode code listed below.
package canwk_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_RXONLY  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_GOSLEEP = 3'd3,
        MODE_SLEEP   = 3'd4
    } trx_mode_e;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_DOM1 = 3'd1,
        SEQ_REC1 = 3'd2,
        SEQ_DOM2 = 3'd3,
        SEQ_REC2 = 3'd4
    } seq_state_e;

    // True for the low-power modes in which wake-up events are watched.
    function automatic logic mode_watches(input logic [2:0] m);
        return (m == MODE_STANDBY) || (m == MODE_GOSLEEP) || (m == MODE_SLEEP);
    endfunction

endpackage

// File: rtl/canwk_phase_seq.sv
// Remote wake-up pattern sequencer.
// Recognises dominant >= DOM_TICKS, recessive >= REC_TICKS, twice over.
// Phase length counts ticks seen in the phase, including its first clock.
// Any phase ending short returns to idle. Assumes bus_dom is synchronous.
module canwk_phase_seq #(
    parameter int DOM_TICKS = 3,
    parameter int REC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic bus_dom,
    output logic remote_hit
);
    import canwk_pkg::*;

    localparam int CMAX = (DOM_TICKS > REC_TICKS) ? DOM_TICKS : REC_TICKS;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] DOM_TH = CW'(DOM_TICKS);
    localparam logic [CW-1:0] REC_TH = CW'(REC_TICKS);
    localparam logic [CW-1:0] CNT_TOP = CW'(CMAX);

    seq_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n, cnt_inc, cnt_start;

    // Saturating tick count within the current phase, and the entry value.
    always_comb begin
        cnt_inc   = (tick && (cnt != CNT_TOP)) ? cnt + CW'(1) : cnt;
        cnt_start = tick ? CW'(1) : '0;
    end

    // Next-state decision for the pattern.
    always_comb begin
        st_n       = st;
        cnt_n      = cnt_inc;
        remote_hit = 1'b0;
        if (!enable) begin
            st_n  = SEQ_IDLE;
            cnt_n = '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (bus_dom) begin
                        st_n  = SEQ_DOM1;
                        cnt_n = cnt_start;
                    end else begin
                        cnt_n = '0;
                    end
                end
                SEQ_DOM1, SEQ_DOM2: begin
                    if (!bus_dom) begin
                        if (cnt >= DOM_TH) begin
                            st_n  = (st == SEQ_DOM1) ? SEQ_REC1 : SEQ_REC2;
                            cnt_n = cnt_start;
                        end else begin
                            st_n  = SEQ_IDLE;
                            cnt_n = '0;
                        end
                    end
                end
                SEQ_REC1: begin
                    if (bus_dom) begin
                        if (cnt >= REC_TH) begin
                            st_n  = SEQ_DOM2;
                            cnt_n = cnt_start;
                        end else begin
                            st_n  = SEQ_IDLE;
                            cnt_n = '0;
                        end
                    end
                end
                SEQ_REC2: begin
                    if (cnt >= REC_TH) begin
                        remote_hit = 1'b1;
                        st_n       = SEQ_IDLE;
                        cnt_n      = '0;
                    end else if (bus_dom) begin
                        st_n  = SEQ_IDLE;
                        cnt_n = '0;
                    end
                end
                default: begin
                    st_n  = SEQ_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

endmodule

// File: rtl/canwk_level_debounce.sv
// Wake pin debouncer.
// A level differing from the accepted one for WAKE_TICKS consecutive ticks
// becomes the new accepted level. change_hit marks the clock of acceptance.
// The accepted level resets low and drives the bias direction.
module canwk_level_debounce #(
    parameter int WAKE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic level,
    output logic stable_lvl,
    output logic change_hit
);
    localparam int CW = $clog2(WAKE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          differs;

    // Acceptance happens on the tick that completes the stable window.
    always_comb begin
        differs    = (level != stable_lvl);
        change_hit = differs && tick && (cnt == LAST);
    end

    // Stability counter and accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_lvl <= 1'b0;
            cnt        <= '0;
        end else if (!differs) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                stable_lvl <= level;
                cnt        <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/canwk_flag_ctrl.sv
// Wake-up flag keeper.
// Sets the two flags from detection hits under the mode, blocking and
// power-up gating, and clears them on power-up, undervoltage and mode
// transitions. Clears take priority over sets.
module canwk_flag_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       uv_block,
    input  logic       pwrup_flag,
    input  logic       pwrup_evt,
    input  logic       uv_set,
    input  logic       remote_hit,
    input  logic       local_hit,
    output logic       detect_en,
    output logic       wake_flag,
    output logic       local_flag
);
    import canwk_pkg::*;

    logic [2:0] prev_mode;
    logic       enter_normal, leave_normal;
    logic       set_wake, set_local, clr_wake, clr_local;

    // Detection window, mode-transition events and set/clear terms.
    always_comb begin
        detect_en    = mode_watches(mode) && !uv_block;
        enter_normal = (mode == MODE_NORMAL) && (prev_mode != MODE_NORMAL);
        leave_normal = (mode != MODE_NORMAL) && (prev_mode == MODE_NORMAL);
        set_wake     = detect_en && (remote_hit || local_hit);
        set_local    = detect_en && local_hit && !pwrup_flag;
        clr_wake     = pwrup_evt || uv_set || enter_normal;
        clr_local    = pwrup_evt || leave_normal;
    end

    // Flag registers and previous-mode memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mode  <= MODE_STANDBY;
            wake_flag  <= 1'b0;
            local_flag <= 1'b0;
        end else begin
            prev_mode <= mode;
            if (clr_wake)      wake_flag <= 1'b0;
            else if (set_wake) wake_flag <= 1'b1;
            if (clr_local)      local_flag <= 1'b0;
            else if (set_local) local_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/canwk_detector.sv
// CAN wake-up detector top.
// Combines the remote pattern sequencer, the wake pin debouncer and the flag
// keeper. All inputs are assumed synchronous to clk. tick is a one-clock
// enable at the low duration-measurement rate.
module canwk_detector #(
    parameter int DOM_TICKS  = 3,
    parameter int REC_TICKS  = 2,
    parameter int WAKE_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] mode,
    input  logic       bus_dom,
    input  logic       wake_lvl,
    input  logic       uv_block,
    input  logic       pwrup_flag,
    input  logic       pwrup_evt,
    input  logic       uv_set,
    output logic       wake_flag,
    output logic       local_flag,
    output logic       wake_pull_up
);
    logic remote_hit, local_hit, detect_en, pin_lvl;

    canwk_phase_seq #(
        .DOM_TICKS(DOM_TICKS),
        .REC_TICKS(REC_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (detect_en),
        .bus_dom   (bus_dom),
        .remote_hit(remote_hit)
    );

    canwk_level_debounce #(
        .WAKE_TICKS(WAKE_TICKS)
    ) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .level     (wake_lvl),
        .stable_lvl(pin_lvl),
        .change_hit(local_hit)
    );

    canwk_flag_ctrl u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .uv_block  (uv_block),
        .pwrup_flag(pwrup_flag),
        .pwrup_evt (pwrup_evt),
        .uv_set    (uv_set),
        .remote_hit(remote_hit),
        .local_hit (local_hit),
        .detect_en (detect_en),
        .wake_flag (wake_flag),
        .local_flag(local_flag)
    );

    // Bias direction follows the accepted pin level.
    assign wake_pull_up = pin_lvl;

endmodule

// File: rtl/canwk_detector_chk.sv
// Port-level property checker for canwk_detector, attached by bind.
module canwk_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       wake_lvl,
    input logic       uv_block,
    input logic       pwrup_flag,
    input logic       pwrup_evt,
    input logic       uv_set,
    input logic       wake_flag,
    input logic       local_flag,
    input logic       wake_pull_up
);
    logic quiet_mode;
    assign quiet_mode = (mode == 3'd0) || (mode == 3'd1);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!wake_flag && !local_flag && !wake_pull_up));

    a_r6_no_set_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_mode |=> (!$rose(wake_flag) && !$rose(local_flag)));

    a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        uv_block |=> (!$rose(wake_flag) && !$rose(local_flag)));

    a_r8_pwrup_gates_local: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup_flag |=> !$rose(local_flag));

    a_r9_local_clear_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup_evt |=> !local_flag);

    a_r9_local_clear_leave: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (mode != 3'd0) && ($past(mode) == 3'd0)) |=> !local_flag);

    a_r10_wake_clear_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrup_evt || uv_set) |=> !wake_flag);

    a_r10_wake_clear_enter: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (mode == 3'd0) && ($past(mode) != 3'd0)) |=> !wake_flag);

    a_r5_pull_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(wake_pull_up)) |-> (wake_pull_up == $past(wake_lvl)));

endmodule

bind canwk_detector canwk_detector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .wake_lvl    (wake_lvl),
    .uv_block    (uv_block),
    .pwrup_flag  (pwrup_flag),
    .pwrup_evt   (pwrup_evt),
    .uv_set      (uv_set),
    .wake_flag   (wake_flag),
    .local_flag  (local_flag),
    .wake_pull_up(wake_pull_up)
);

// File: tb/canwk_detector_bench.sv
// Self-checking bench: sweeps remote phase lengths and pin pulse widths.
module canwk_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DOM = 3;
    localparam int REC = 2;
    localparam int WK  = 4;

    logic       clk = 1'b0;
    logic       rst_n, tick, bus_dom, wake_lvl, uv_block, pwrup_flag, pwrup_evt, uv_set;
    logic [2:0] mode;
    logic       wake_flag, local_flag, wake_pull_up;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    canwk_detector #(.DOM_TICKS(DOM), .REC_TICKS(REC), .WAKE_TICKS(WK)) u_canwk_detector (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .bus_dom(bus_dom),
        .wake_lvl(wake_lvl), .uv_block(uv_block), .pwrup_flag(pwrup_flag),
        .pwrup_evt(pwrup_evt), .uv_set(uv_set), .wake_flag(wake_flag),
        .local_flag(local_flag), .wake_pull_up(wake_pull_up)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pass through normal mode to empty both flags, end in standby.
    task automatic clear_flags();
        bus_dom = 1'b0;
        mode = 3'd0;
        step(2);
        mode = 3'd2;
        step(1);
    endtask

    task automatic remote(input int d1, input int r1, input int d2, input int r2);
        bus_dom = 1'b1; step(d1);
        bus_dom = 1'b0; step(r1);
        bus_dom = 1'b1; step(d2);
        bus_dom = 1'b0; step(r2);
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b1; mode = 3'd2; bus_dom = 1'b0; wake_lvl = 1'b0;
        uv_block = 1'b0; pwrup_flag = 1'b0; pwrup_evt = 1'b0; uv_set = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 wake_flag after reset", wake_flag, 1'b0);
        chk("R1 local_flag after reset", local_flag, 1'b0);
        chk("R1 pull-down after reset", wake_pull_up, 1'b0);

        // R2/R3: sweep first three phase lengths, long final recessive phase.
        for (int d1 = 1; d1 <= 4; d1++)
            for (int r1 = 1; r1 <= 4; r1++)
                for (int d2 = 1; d2 <= 4; d2++) begin
                    clear_flags();
                    remote(d1, r1, d2, REC + 2);
                    chk($sformatf("R2/R3 remote d1=%0d r1=%0d d2=%0d", d1, r1, d2), wake_flag,
                        (d1 >= DOM) && (r1 >= REC) && (d2 >= DOM));
                    chk("R2 remote leaves local_flag", local_flag, 1'b0);
                end

        // R2 exact timing of the final recessive phase.
        clear_flags();
        remote(DOM, REC, DOM, REC);
        chk("R2 not yet set at REC ticks", wake_flag, 1'b0);
        step(1);
        chk("R2 set one clock later", wake_flag, 1'b1);

        // R3 short final recessive phase.
        clear_flags();
        remote(DOM + 1, REC + 1, DOM + 1, REC - 1);
        bus_dom = 1'b1; step(1);
        bus_dom = 1'b0; step(REC + 3);
        chk("R3 short last recessive discards", wake_flag, 1'b0);

        // R4/R5: pin pulse width sweep from both resting levels.
        for (int base = 0; base <= 1; base++) begin
            wake_lvl = base[0];
            step(WK + 2);
            chk("R5 pull matches resting level", wake_pull_up, base[0]);
            clear_flags();
            for (int w = 1; w <= WK + 2; w++) begin
                wake_lvl = !base[0];
                step(w);
                chk($sformatf("R4 local_flag base=%0d w=%0d", base, w), local_flag, w >= WK);
                chk($sformatf("R4 wake_flag base=%0d w=%0d", base, w), wake_flag, w >= WK);
                chk($sformatf("R5 pull base=%0d w=%0d", base, w), wake_pull_up,
                    (w >= WK) ? !base[0] : base[0]);
                wake_lvl = base[0];
                step(WK + 2);
                chk($sformatf("R5 pull back base=%0d w=%0d", base, w), wake_pull_up, base[0]);
                clear_flags();
            end
        end
        // wake_lvl is now 1 and accepted.

        // R6: normal and receive-only modes set nothing.
        mode = 3'd0; step(1);
        remote(DOM + 1, REC + 1, DOM + 1, REC + 2);
        chk("R6 normal mode ignores bus", wake_flag, 1'b0);
        mode = 3'd1; step(1);
        remote(DOM + 1, REC + 1, DOM + 1, REC + 2);
        wake_lvl = 1'b0; step(WK + 1);
        chk("R6 rx-only ignores bus and pin", wake_flag, 1'b0);
        chk("R6 rx-only local_flag", local_flag, 1'b0);
        chk("R5 pull follows pin in rx-only", wake_pull_up, 1'b0);
        mode = 3'd3; step(1);
        remote(DOM, REC, DOM, REC + 2);
        chk("R2 go-to-sleep detects", wake_flag, 1'b1);
        clear_flags();
        mode = 3'd4; step(1);
        remote(DOM, REC, DOM, REC + 2);
        chk("R2 sleep detects", wake_flag, 1'b1);
        clear_flags();

        // R7: blocked window.
        uv_block = 1'b1;
        remote(DOM + 1, REC + 1, DOM + 1, REC + 2);
        wake_lvl = 1'b1; step(WK + 1);
        chk("R7 blocked wake_flag", wake_flag, 1'b0);
        chk("R7 blocked local_flag", local_flag, 1'b0);
        chk("R5 pull follows pin while blocked", wake_pull_up, 1'b1);
        uv_block = 1'b0;

        // R8: power-up flag gates local flag only.
        pwrup_flag = 1'b1;
        wake_lvl = 1'b0; step(WK + 1);
        chk("R8 wake_flag set", wake_flag, 1'b1);
        chk("R8 local_flag held clear", local_flag, 1'b0);
        pwrup_flag = 1'b0;
        clear_flags();

        // R9/R10: clear events.
        wake_lvl = 1'b1; step(WK + 1);
        chk("R4 both set before clears", local_flag & wake_flag, 1'b1);
        pwrup_evt = 1'b1; step(1); pwrup_evt = 1'b0;
        chk("R9 pwrup_evt clears local", local_flag, 1'b0);
        chk("R10 pwrup_evt clears wake", wake_flag, 1'b0);
        wake_lvl = 1'b0; step(WK + 1);
        mode = 3'd0; step(1);
        chk("R10 entering normal clears wake", wake_flag, 1'b0);
        chk("R9 entering normal keeps local", local_flag, 1'b1);
        mode = 3'd2; step(1);
        chk("R9 leaving normal clears local", local_flag, 1'b0);
        wake_lvl = 1'b1; step(WK + 1);
        uv_set = 1'b1; step(1); uv_set = 1'b0;
        chk("R10 uv_set clears wake", wake_flag, 1'b0);
        chk("R10 uv_set keeps local", local_flag, 1'b1);
        clear_flags();

        // R11: no progress without tick.
        tick = 1'b0;
        remote(DOM + 3, REC + 3, DOM + 3, REC + 3);
        chk("R11 no remote wake without tick", wake_flag, 1'b0);
        wake_lvl = 1'b0; step(WK + 6);
        chk("R11 pin not accepted without tick", wake_pull_up, 1'b1);
        tick = 1'b1;
        step(WK - 1);
        chk("R11 pin one tick short", wake_pull_up, 1'b1);
        step(1);
        chk("R11 pin accepted after WK ticks", wake_pull_up, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule